// File: doc/BRIEF.md
# Atomic Lock Arbiter

This block serialises locked read-modify-write operations issued by several hardware threads against one shared memory. A thread raises its lock request together with an opcode, a target address and an operand. The arbiter picks one requester, waits until that thread's own store buffer has emptied, and then reads the target word. In the next cycle it writes back either the sum of the old value and the operand, or the operand alone. It then waits again for the holder's store buffer to empty and releases the lock. On release it returns the old value with a one-cycle completion pulse.

While the lock is held, every other thread receives a read-block signal, which stalls its shared-memory loads, and a drain-hold signal, which keeps its store buffer from writing to memory. The holder's own store buffer is never held back, so the writes that precede or accompany the locked operation can reach memory. Each locked operation therefore acts as a full barrier for its thread.

Top module: `atomic_lock_arbiter`

## Requirements
- R1: At most one thread holds the lock (`lock_grant` is zero or one-hot), and a grant goes only to a thread whose `lock_req` is high.
- R2: While thread h holds the lock, `rd_block` is high for every thread other than h and low for h. With no holder, `rd_block` is all zero.
- R3: While thread h holds the lock, `drain_hold` is high for every thread other than h and low for h. With no holder, `drain_hold` is all zero.
- R4: The shared-memory read of a locked operation is issued only in a cycle in which the holder's `sb_empty` is high, so all of that thread's earlier buffered writes have drained first.
- R5: The write follows the read in the very next cycle, to the same address. Opcode bit 0 writes old value plus operand, modulo 2^DW. Opcode bit 1 writes the operand (exchange).
- R6: Completion is a one-cycle pulse on the holder's `lock_done` bit, with `done_old` carrying the value read before the write. It comes only after a cycle in which the holder still held the lock and its `sb_empty` was high.
- R7: Arbitration is round robin. After thread w is granted, the search for the next grant starts at thread w+1 (wrapping to 0), so a requester that holds its request is never starved.
- R8: After a completion pulse, the following cycle has no grant. The cycle after that shows a grant exactly when some request was pending in the intervening cycle.
- R9: After reset there is no grant, no completion, no block, no hold and no memory access, and the round-robin search starts at thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_req | input | NT | Per-thread lock request, held until `lock_done` |
| req_op | input | NT | Per-thread opcode: 0 fetch-add, 1 exchange |
| req_addr | input | NT*AW | Per-thread target address, packed |
| req_operand | input | NT*DW | Per-thread operand, packed |
| sb_empty | input | NT | Per-thread store buffer empty flag |
| lock_grant | output | NT | One-hot lock holder |
| lock_done | output | NT | One-cycle completion pulse to the holder |
| done_old | output | DW | Value read before the write, valid with `lock_done` |
| rd_block | output | NT | Stall shared-memory reads of this thread |
| drain_hold | output | NT | Inhibit store-buffer drain of this thread |
| mem_rd | output | 1 | Shared-memory read strobe |
| mem_wr | output | 1 | Shared-memory write strobe |
| mem_addr | output | AW | Shared-memory address |
| mem_wdata | output | DW | Shared-memory write data |
| mem_rdata | input | DW | Read data, one cycle after `mem_rd` |

## Verification
The bench builds the block with four threads, a 4-bit address and a 16-bit data word. Four threads are enough for the round-robin pointer to wrap and for several threads to pile up behind a holder while their store buffers are frozen. Sixteen addresses make random operations collide on the same word often, so ordering errors appear in the returned old values. The 16-bit word lets a fetch-add carry out of the top bit with a directed operand.

// File: rtl/alk_pkg.sv
package alk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GRANT   = 3'd1,
        ST_RMW     = 3'd2,
        ST_FLUSH   = 3'd3,
        ST_RELEASE = 3'd4
    } lock_state_e;

    typedef enum logic {
        OP_FADD = 1'b0,
        OP_XCHG = 1'b1
    } atom_op_e;

    function automatic lock_state_e lock_next(input lock_state_e cur,
                                              input logic any_req,
                                              input logic holder_empty);
        lock_state_e nxt;
        nxt = cur;
        case (cur)
            ST_IDLE:    nxt = any_req ? ST_GRANT : ST_IDLE;
            ST_GRANT:   nxt = holder_empty ? ST_RMW : ST_GRANT;
            ST_RMW:     nxt = ST_FLUSH;
            ST_FLUSH:   nxt = holder_empty ? ST_RELEASE : ST_FLUSH;
            ST_RELEASE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic logic lock_is_held(input lock_state_e cur);
        return (cur == ST_GRANT) || (cur == ST_RMW) || (cur == ST_FLUSH);
    endfunction

endpackage

// File: rtl/alk_rr_pick.sv
module alk_rr_pick #(
    parameter int NT = 4,
    localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [NT-1:0] req,
    input  logic [IW-1:0] start,
    output logic [IW-1:0] win,
    output logic          any
);
    always_comb begin
        int idx;
        win = '0;
        any = |req;
        for (int k = NT - 1; k >= 0; k--) begin
            idx = (int'(start) + k) % NT;
            if (req[idx]) win = IW'(idx);
        end
    end
endmodule

// File: rtl/alk_rmw_unit.sv
module alk_rmw_unit
    import alk_pkg::*;
#(
    parameter int DW = 16
) (
    input  atom_op_e      op,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] old_val,
    output logic [DW-1:0] new_val
);
    always_comb begin
        if (op == OP_XCHG) new_val = operand;
        else               new_val = old_val + operand;
    end
endmodule

// File: rtl/atomic_lock_arbiter.sv
module atomic_lock_arbiter
    import alk_pkg::*;
#(
    parameter int NT = 4,
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int IW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NT-1:0]    lock_req,
    input  logic [NT-1:0]    req_op,
    input  logic [NT*AW-1:0] req_addr,
    input  logic [NT*DW-1:0] req_operand,
    input  logic [NT-1:0]    sb_empty,
    output logic [NT-1:0]    lock_grant,
    output logic [NT-1:0]    lock_done,
    output logic [DW-1:0]    done_old,
    output logic [NT-1:0]    rd_block,
    output logic [NT-1:0]    drain_hold,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata
);
    lock_state_e   state_q;
    logic [IW-1:0] owner_q;
    logic [IW-1:0] ptr_q;
    logic [DW-1:0] old_q;
    logic [IW-1:0] win;
    logic          any_req;
    logic          held;
    logic          holder_empty;
    logic [NT-1:0] holder_1h;
    atom_op_e      holder_op;
    logic [DW-1:0] holder_operand;

    alk_rr_pick #(.NT(NT)) u_pick (
        .req   (lock_req),
        .start (ptr_q),
        .win   (win),
        .any   (any_req)
    );

    assign held           = lock_is_held(state_q);
    assign holder_empty   = sb_empty[owner_q];
    assign holder_1h      = NT'(1) << owner_q;
    assign holder_op      = atom_op_e'(req_op[owner_q]);
    assign holder_operand = req_operand[owner_q*DW +: DW];

    alk_rmw_unit #(.DW(DW)) u_rmw (
        .op      (holder_op),
        .operand (holder_operand),
        .old_val (mem_rdata),
        .new_val (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            ptr_q   <= '0;
            old_q   <= '0;
        end else begin
            state_q <= lock_next(state_q, any_req, holder_empty);
            if (state_q == ST_IDLE && any_req) begin
                owner_q <= win;
                ptr_q   <= (win == IW'(NT - 1)) ? '0 : win + 1'b1;
            end
            if (state_q == ST_RMW) old_q <= mem_rdata;
        end
    end

    assign mem_rd     = (state_q == ST_GRANT) && holder_empty;
    assign mem_wr     = (state_q == ST_RMW);
    assign mem_addr   = req_addr[owner_q*AW +: AW];
    assign lock_grant = held ? holder_1h : '0;
    assign rd_block   = held ? ~holder_1h : '0;
    assign drain_hold = held ? ~holder_1h : '0;
    assign lock_done  = (state_q == ST_RELEASE) ? holder_1h : '0;
    assign done_old   = old_q;

    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lock_grant));
    p_grant_to_req_r1: assert property (@(posedge clk) disable iff (rst)
        (|lock_grant) |-> (|(lock_grant & lock_req)));
    p_block_others_r2: assert property (@(posedge clk) disable iff (rst)
        (|lock_grant) |-> ((rd_block & lock_grant) == '0
                           && $countones(rd_block) == NT - 1));
    p_no_block_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (lock_grant == '0) |-> (rd_block == '0));
    p_hold_others_r3: assert property (@(posedge clk) disable iff (rst)
        (|lock_grant) |-> ((drain_hold & lock_grant) == '0
                           && $countones(drain_hold) == NT - 1));
    p_read_after_drain_r4: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (|(lock_grant & sb_empty)));
    p_write_follows_read_r5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ($past(mem_rd) && $stable(mem_addr)));
    p_done_after_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (|lock_done) |-> ($past(|(lock_grant & sb_empty)) && $past(lock_done) == '0));
    p_idle_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        (|lock_done) |=> (lock_grant == '0));
endmodule

// File: tb/atomic_lock_arbiter_bench.sv
module atomic_lock_arbiter_bench;
    localparam int NT = 4;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int ND = 1 << AW;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NT-1:0]    lock_req = '0;
    logic [NT-1:0]    req_op = '0;
    logic [NT*AW-1:0] req_addr = '0;
    logic [NT*DW-1:0] req_operand = '0;
    logic [NT-1:0]    sb_empty;
    logic [NT-1:0]    lock_grant, lock_done, rd_block, drain_hold;
    logic [DW-1:0]    done_old, mem_wdata;
    logic [DW-1:0]    mem_rdata = '0;
    logic             mem_rd, mem_wr;
    logic [AW-1:0]    mem_addr;

    logic [DW-1:0] mem     [ND];
    logic [DW-1:0] ref_mem [ND];
    int            sb_cnt  [NT];
    logic [NT-1:0] ld = '0;
    int            ld_val  [NT];
    int            extra   [NT];

    int n_chk = 0, n_fail = 0;
    int exp_ptr = 0;
    int done_age = 99;
    int completions = 0;
    logic [NT-1:0] prev_grant = '0, prev_done = '0;
    logic          prev_hold_empty = 1'b0, prev_rd = 1'b0;
    logic [AW-1:0] prev_rd_addr = '0;

    always #2 clk = ~clk;

    atomic_lock_arbiter #(.NT(NT), .AW(AW), .DW(DW)) u_atomic_lock_arbiter (
        .clk(clk), .rst(rst), .lock_req(lock_req), .req_op(req_op),
        .req_addr(req_addr), .req_operand(req_operand), .sb_empty(sb_empty),
        .lock_grant(lock_grant), .lock_done(lock_done), .done_old(done_old),
        .rd_block(rd_block), .drain_hold(drain_hold), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    for (genvar g = 0; g < NT; g++) begin : g_sb
        assign sb_empty[g] = (sb_cnt[g] == 0);
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < ND; a++) mem[a] <= 16'(a * 37 + 5);
            for (int i = 0; i < NT; i++) sb_cnt[i] <= 0;
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr];
            if (mem_wr) mem[mem_addr] <= mem_wdata;
            for (int i = 0; i < NT; i++) begin
                if (ld[i]) sb_cnt[i] <= ld_val[i];
                else if (mem_wr && lock_grant[i]) sb_cnt[i] <= extra[i];
                else if (!drain_hold[i] && sb_cnt[i] != 0) sb_cnt[i] <= sb_cnt[i] - 1;
            end
        end
    end

    task automatic chk(input logic ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [NT-1:0] v);
        int r = 0;
        for (int i = 0; i < NT; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [DW-1:0] exp_new(input int h, input logic [DW-1:0] old);
        logic [DW-1:0] opd = req_operand[h*DW +: DW];
        return req_op[h] ? opd : old + opd;
    endfunction

    task automatic tick();
        logic [NT-1:0] expb;
        int h, w;
        @(negedge clk);
        ld = '0;
        expb = (|lock_grant) ? ~lock_grant : '0;
        chk($onehot0(lock_grant) && ((lock_grant & ~lock_req) == '0), "R1",
            32'(lock_grant), 32'(lock_req));
        chk(rd_block == expb, "R2", 32'(rd_block), 32'(expb));
        chk(drain_hold == expb, "R3", 32'(drain_hold), 32'(expb));
        if (mem_rd) chk(|(lock_grant & sb_empty), "R4", 32'(sb_empty), 32'(lock_grant));
        if (mem_wr) begin
            h = idx_of(lock_grant);
            chk(prev_rd && prev_rd_addr == mem_addr
                && mem_addr == req_addr[h*AW +: AW], "R5 addr",
                32'(mem_addr), 32'(req_addr[h*AW +: AW]));
            chk(mem_wdata == exp_new(h, ref_mem[mem_addr]), "R5 data",
                32'(mem_wdata), 32'(exp_new(h, ref_mem[mem_addr])));
        end
        if (|lock_grant && prev_grant == '0) begin
            w = exp_ptr;
            for (int k = NT - 1; k >= 0; k--)
                if (lock_req[(exp_ptr + k) % NT]) w = (exp_ptr + k) % NT;
            chk(lock_grant == NT'(1) << w, "R7", 32'(lock_grant), 32'(1) << w);
            exp_ptr = (w + 1) % NT;
        end
        done_age++;
        if (done_age == 1) chk(lock_grant == '0, "R8 gap", 32'(lock_grant), 0);
        if (done_age == 2) chk((|lock_grant) == (|lock_req), "R8 regrant",
                               32'(lock_grant), 32'(lock_req));
        if (|lock_done) begin
            h = idx_of(lock_done);
            chk($onehot(lock_done) && lock_done == prev_grant && prev_hold_empty
                && prev_done == '0, "R6 pulse", 32'(lock_done), 32'(prev_grant));
            chk(done_old == ref_mem[req_addr[h*AW +: AW]], "R6 old",
                32'(done_old), 32'(ref_mem[req_addr[h*AW +: AW]]));
            ref_mem[req_addr[h*AW +: AW]] = exp_new(h, ref_mem[req_addr[h*AW +: AW]]);
            lock_req[h] = 1'b0;
            completions++;
            done_age = 0;
        end
        prev_grant      = lock_grant;
        prev_done       = lock_done;
        prev_hold_empty = |(lock_grant & sb_empty);
        prev_rd         = mem_rd;
        prev_rd_addr    = mem_addr;
    endtask

    task automatic issue(input int i, input logic op, input logic [AW-1:0] a,
                         input logic [DW-1:0] opd, input int sbd, input int ex);
        req_op[i] = op;
        req_addr[i*AW +: AW] = a;
        req_operand[i*DW +: DW] = opd;
        ld_val[i] = sbd;
        extra[i] = ex;
        ld[i] = 1'b1;
        lock_req[i] = 1'b1;
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 400; t++) begin
            if (lock_req == '0 && lock_grant == '0) break;
            tick();
        end
        chk(lock_req == '0, "R7 no starvation", 32'(lock_req), 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int a = 0; a < ND; a++) ref_mem[a] = 16'(a * 37 + 5);
        for (int i = 0; i < NT; i++) begin ld_val[i] = 0; extra[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(lock_grant == '0 && lock_done == '0 && rd_block == '0 && drain_hold == '0
            && !mem_rd && !mem_wr, "R9", 32'({lock_grant, lock_done, rd_block}), 0);

        issue(2, 1'b0, 4'd5, 16'h0010, 3, 2);
        wait_idle();
        issue(0, 1'b1, 4'd5, 16'hBEEF, 0, 0);
        wait_idle();
        issue(1, 1'b0, 4'd7, 16'hFFFF, 1, 1);
        wait_idle();
        chk(ref_mem[7] == 16'(7 * 37 + 5 - 1), "R5 wrap", 32'(ref_mem[7]),
            32'(16'(7 * 37 + 5 - 1)));
        for (int i = 0; i < NT; i++) issue(i, i[0], 4'd3, 16'(i + 1), i, 1);
        wait_idle();
        issue(3, 1'b0, 4'd9, 16'h0001, 2, 2);
        tick();
        issue(1, 1'b0, 4'd9, 16'h0002, 3, 0);
        wait_idle();

        for (int it = 0; it < 1500; it++) begin
            tick();
            for (int i = 0; i < NT; i++)
                if (!lock_req[i] && ($urandom % 4) == 0)
                    issue(i, 1'($urandom), AW'($urandom), DW'($urandom),
                          int'($urandom % 4), int'($urandom % 3));
        end
        wait_idle();
        tick();
        for (int a = 0; a < ND; a++)
            chk(mem[a] == ref_mem[a], "R5 final", 32'(mem[a]), 32'(ref_mem[a]));
        chk(completions > 100, "R6 count", completions, 100);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule